// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block sits on the host side of a parallel NOR flash device. It runs after the host has started an embedded program or erase operation in the device. Once started, it issues status reads over a simple synchronous 8-bit bus. It decides that the operation has finished when the toggle bit (data bit 6) holds the same value across two compared reads. While the toggle bit keeps changing, it also watches the exceeded-limit flag (data bit 5). When that flag rises, it takes a fresh pair of reads, because the toggle may have stopped just as the flag went high. Only if the bit still changes in that pair is the operation declared failed.

On failure the poller writes the reset command (data 8'hF0) to the polled address. This returns the device to array-read mode. The poller then reports an error to its client. A configurable limit on the number of compares guards against a device that never settles. Hitting it ends polling with a separate error code, after the same reset write.

The client drives a start pulse with an address and receives a one-cycle done or error pulse. The client may abandon polling with an abort. After an abort, the next start begins again from a fresh pair of reads.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o, bus_rd_o and bus_wr_o are all low and err_code_o is 2'b00.
- R2: A start_i pulse while idle captures addr_i. The poller then issues two status reads to that address before it makes any decision, so a device whose bit 6 never changes ends polling after exactly two reads.
- R3: When bit 6 of the two compared reads is equal, done_o pulses with busy_o low, and no bus write is issued.
- R4: When bit 6 differs and bit 5 of the later read is 0, the poller issues exactly one more read and compares it against the previous read.
- R5: When bit 6 differs and bit 5 of the later read is 1, the poller discards both values and takes a fresh pair of reads. If bit 6 is equal in that pair, the result is done.
- R6: If bit 6 still differs in the fresh pair taken after bit 5 rose, the poller issues one bus write of 8'hF0 to the captured address. In the next cycle it pulses err_o with err_code_o = 2'b01.
- R7: If the MAX_LOOPS-th compare reaches no result, the poller issues the same single 8'hF0 write and then pulses err_o with err_code_o = 2'b10. A pending re-check takes precedence over this limit.
- R8: start_i is ignored while busy_o is high. The bus address stays the one captured at the accepted start, and only one result pulse follows.
- R9: abort_i while a read is being issued, awaited or evaluated returns the poller to idle with no done_o or err_o pulse. The next start discards every stored status value.
- R10: done_o and err_o are single-cycle pulses that are never high together. bus_rd_o and bus_wr_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| abort_i | input | 1 | Abandon polling in progress |
| addr_i | input | AW | Address used for status reads and the reset write |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle pulse: operation completed |
| err_o | output | 1 | One-cycle pulse: operation failed or limit hit |
| err_code_o | output | 2 | With err_o: 01 device failure, 10 loop limit |
| bus_rd_o | output | 1 | One-cycle status read request |
| bus_wr_o | output | 1 | One-cycle write request |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Write data (reset command) |
| bus_rdata_i | input | DW | Read data, valid with bus_rvalid_i |
| bus_rvalid_i | input | 1 | Read data valid, one or more cycles after bus_rd_o |

## Verification
The hardest situation to reach from the ports is the race the re-check exists for. Bit 5 must rise on a read while bit 6 is still changing, and bit 6 must then settle exactly within the following fresh pair, or fail to. The bench models the device as a read counter. It has two settings: the read index after which bit 6 stops changing, and the read index from which bit 5 reads 1. It places those indices one or two reads apart to hit both outcomes of the re-check, and spreads them randomly around the compare limit, with random read latency.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WT,
      ST_EVAL,
      ST_RST
   } tsp_state_e;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'b00,
      ERR_DEVICE = 2'b01,
      ERR_LIMIT  = 2'b10
   } tsp_err_e;

   localparam logic [7:0] RESET_CMD = 8'hF0;
endpackage

// File: rtl/tgl_loop_ctr.sv
module tgl_loop_ctr #(
   parameter int MAX_LOOPS = 64,
   localparam int CW = $clog2(MAX_LOOPS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt_q <= '0;
      else if (clr_i)                            cnt_q <= '0;
      else if (inc_i && cnt_q != CW'(MAX_LOOPS)) cnt_q <= cnt_q + 1'b1;
   end

   // compare being evaluated now is the MAX_LOOPS-th one
   assign last_o = (cnt_q == CW'(MAX_LOOPS - 1));

   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_LOOPS));
endmodule

// File: rtl/tgl_bit_tap.sv
module tgl_bit_tap #(
   parameter bit SLIDING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic cap_i,
   input  logic adv_i,
   input  logic tgl_i,
   input  logic flg_i,
   output logic have_o,
   output logic differ_o,
   output logic flag_o
);
   logic first_q, second_q, flag_q, have_q, keep_first;

   generate
      if (SLIDING) begin : g_slide
         assign keep_first = 1'b1;   // latest read becomes the new reference
      end else begin : g_pair
         assign keep_first = 1'b0;   // every loop takes a full fresh pair
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= 1'b0;
         second_q <= 1'b0;
         flag_q   <= 1'b0;
         have_q   <= 1'b0;
      end else if (clr_i) begin
         have_q <= 1'b0;
      end else if (cap_i) begin
         if (!have_q) begin
            first_q <= tgl_i;
            have_q  <= 1'b1;
         end else begin
            second_q <= tgl_i;
            flag_q   <= flg_i;
         end
      end else if (adv_i) begin
         first_q <= second_q;
         have_q  <= keep_first;
      end
   end

   assign have_o   = have_q;
   assign differ_o = first_q ^ second_q;
   assign flag_o   = flag_q;
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
   import tsp_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 16,
   parameter int TGL_BIT   = 6,
   parameter int FLG_BIT   = 5,
   parameter int MAX_LOOPS = 64,
   parameter bit SLIDING   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          abort_i,
   input  logic [AW-1:0] addr_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o,
   output logic [1:0]    err_code_o,
   output logic          bus_rd_o,
   output logic          bus_wr_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic [DW-1:0] bus_rdata_i,
   input  logic          bus_rvalid_i
);
   generate
      if (DW < 8 || TGL_BIT >= DW || FLG_BIT >= DW || TGL_BIT == FLG_BIT) begin : g_bad_bits
         $error("tgl_poll_ctrl: status bit positions do not fit the data width");
      end
      if (MAX_LOOPS < 2) begin : g_bad_loops
         $error("tgl_poll_ctrl: MAX_LOOPS must be at least 2");
      end
   endgenerate

   tsp_state_e    state_q, state_d;
   tsp_err_e      code_q, fin_code;
   logic [AW-1:0] addr_q;
   logic          recheck_q, done_q, err_q;
   logic          tap_clr, tap_cap, tap_adv, have_first, differ, flag;
   logic          cnt_clr, cnt_inc, cnt_last;
   logic          fin_ok, load_code, recheck_set, abort_now;

   assign abort_now = abort_i && (state_q == ST_RD || state_q == ST_WT || state_q == ST_EVAL);
   assign tap_cap   = (state_q == ST_WT) && bus_rvalid_i && !abort_i;

   always_comb begin
      state_d     = state_q;
      tap_clr     = 1'b0;
      tap_adv     = 1'b0;
      cnt_clr     = 1'b0;
      cnt_inc     = 1'b0;
      recheck_set = 1'b0;
      fin_ok      = 1'b0;
      load_code   = 1'b0;
      fin_code    = ERR_NONE;
      case (state_q)
         ST_IDLE: if (start_i) begin
            state_d = ST_RD;
            tap_clr = 1'b1;
            cnt_clr = 1'b1;
         end
         ST_RD:   state_d = ST_WT;
         ST_WT:   if (bus_rvalid_i) state_d = have_first ? ST_EVAL : ST_RD;
         ST_EVAL: begin
            cnt_inc = 1'b1;
            if (!differ) begin
               state_d = ST_IDLE;
               fin_ok  = 1'b1;
            end else if (recheck_q) begin
               state_d   = ST_RST;
               fin_code  = ERR_DEVICE;
               load_code = 1'b1;
            end else if (cnt_last) begin
               state_d   = ST_RST;
               fin_code  = ERR_LIMIT;
               load_code = 1'b1;
            end else if (flag) begin
               state_d     = ST_RD;
               recheck_set = 1'b1;
               tap_clr     = 1'b1;
            end else begin
               state_d = ST_RD;
               tap_adv = 1'b1;
            end
         end
         ST_RST:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
      if (abort_now) begin
         state_d   = ST_IDLE;
         fin_ok    = 1'b0;
         load_code = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         code_q    <= ERR_NONE;
         addr_q    <= '0;
         recheck_q <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= fin_ok;
         err_q   <= (state_q == ST_RST);
         if (load_code) code_q <= fin_code;
         if (state_q == ST_IDLE && start_i) begin
            addr_q    <= addr_i;
            recheck_q <= 1'b0;
         end else if (recheck_set) begin
            recheck_q <= 1'b1;
         end
      end
   end

   tgl_bit_tap #(.SLIDING(SLIDING)) u_tap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (tap_clr),
      .cap_i    (tap_cap),
      .adv_i    (tap_adv),
      .tgl_i    (bus_rdata_i[TGL_BIT]),
      .flg_i    (bus_rdata_i[FLG_BIT]),
      .have_o   (have_first),
      .differ_o (differ),
      .flag_o   (flag)
   );

   tgl_loop_ctr #(.MAX_LOOPS(MAX_LOOPS)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .last_o (cnt_last)
   );

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign err_code_o  = err_q ? code_q : ERR_NONE;
   assign bus_rd_o    = (state_q == ST_RD);
   assign bus_wr_o    = (state_q == ST_RST);
   assign bus_addr_o  = addr_q;
   assign bus_wdata_o = DW'(RESET_CMD);

   a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd_o && bus_wr_o));
   a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r6_write_then_err: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |=> (err_o && !busy_o));
   a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !bus_wr_o));
   a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));
   a_r2_eval_has_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EVAL) |-> have_first);
endmodule

// File: tb/sim_tgl_poll_ctrl.sv
`timescale 1ns/1ps
module sim_tgl_poll_ctrl;
   localparam int DW = 8, AW = 16, MAXL = 16;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          start_i = 1'b0, abort_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          busy_o, done_o, err_o, bus_rd_o, bus_wr_o;
   logic [1:0]    err_code_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic [DW-1:0] bus_rdata_i = '0;
   logic          bus_rvalid_i = 1'b0;

   always #2 clk = ~clk;

   tgl_poll_ctrl #(.DW(DW), .AW(AW), .MAX_LOOPS(MAXL)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .addr_i(addr_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
      .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_rvalid_i(bus_rvalid_i));

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;
   // device model settings
   int dev_t = 0, dev_f = 1000, dev_lat = 1, dev_k = 0, dev_dly = 0;
   bit dev_pend = 0;
   // monitor counters
   int rd_cnt, wr_cnt, done_cnt, err_cnt, addr_bad, wdata_bad, wide_cnt, last_code;
   logic [AW-1:0] exp_addr;
   bit prev_done = 0, prev_err = 0;

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic bit tgl_at(int k, int t);
      return 1'((k < t ? k : t) & 1);
   endfunction

   // expected outcome: 0 done, 1 device failure, 2 loop limit
   function automatic int model(int t, int f, output int nreads);
      int  k = 0, cnt = 0, res;
      bit  first, second, flag, re = 0;
      first = tgl_at(k, t); k++;
      forever begin
         second = tgl_at(k, t); flag = (k >= f); k++; cnt++;
         if (first == second) begin res = 0; break; end
         if (re)              begin res = 1; break; end
         if (cnt == MAXL)     begin res = 2; break; end
         if (flag) begin re = 1; first = tgl_at(k, t); k++; end
         else first = second;
      end
      nreads = k;
      return res;
   endfunction

   // device model and bus monitor, both on the falling edge
   initial forever begin
      @(negedge clk);
      if (bus_rd_o) begin
         rd_cnt++;
         if (bus_addr_o != exp_addr) addr_bad++;
      end
      if (bus_wr_o) begin
         wr_cnt++;
         if (bus_addr_o != exp_addr) addr_bad++;
         if (bus_wdata_o != 8'hF0) wdata_bad++;
      end
      if (done_o) done_cnt++;
      if (err_o) begin err_cnt++; last_code = int'(err_code_o); end
      if ((done_o && prev_done) || (err_o && prev_err) || (done_o && err_o)) wide_cnt++;
      if ((bus_rd_o && bus_wr_o)) wide_cnt++;
      prev_done = done_o; prev_err = err_o;
      bus_rvalid_i = 1'b0;
      if (dev_pend) begin
         dev_dly--;
         if (dev_dly == 0) begin
            bus_rdata_i = 8'($urandom);
            bus_rdata_i[6] = tgl_at(dev_k, dev_t);
            bus_rdata_i[5] = (dev_k >= dev_f);
            bus_rvalid_i = 1'b1;
            dev_k++;
            dev_pend = 0;
         end
      end
      if (bus_rd_o) begin dev_pend = 1; dev_dly = dev_lat; end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   task automatic clear_mon();
      rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0;
      addr_bad = 0; wdata_bad = 0; wide_cnt = 0; last_code = 0;
   endtask

   task automatic launch(int t, int f, int lat);
      dev_t = t; dev_f = f; dev_lat = lat; dev_k = 0;
      clear_mon();
      @(negedge clk);
      addr_i = AW'($urandom);
      exp_addr = addr_i;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      addr_i = ~addr_i;
   endtask

   task automatic finish_case(int t, int f, string otag);
      int guard = 0, nr, exp_res, got;
      while (done_cnt + err_cnt == 0 && guard < 5000) begin @(negedge clk); guard++; end
      repeat (4) @(negedge clk);
      exp_res = model(t, f, nr);
      got = (done_cnt == 1 && err_cnt == 0) ? 0 :
            (err_cnt == 1 && done_cnt == 0) ? last_code : 9;
      chk(otag, got, exp_res);
      chk("R4 read count", rd_cnt, nr);
      chk("R6/R7 reset writes", wr_cnt, exp_res == 0 ? 0 : 1);
      chk("R6 write data and address", wdata_bad + addr_bad, 0);
      chk("R10 pulse width and exclusion", wide_cnt, 0);
      chk("R3 idle after result", int'(busy_o), 0);
   endtask

   task automatic run_case(int t, int f, int lat, string otag);
      launch(t, f, lat);
      finish_case(t, f, otag);
   endtask

   initial begin
      int nr, r;
      void'($urandom(32'd20240611));
      clear_mon();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 pulses", int'(done_o) + int'(err_o), 0);
      chk("R1 bus requests", int'(bus_rd_o) + int'(bus_wr_o), 0);
      chk("R1 code", int'(err_code_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2/R3: bit 6 never changes, two reads then done
      run_case(0, 1000, 1, "R3 immediate done");
      chk("R2 two reads", rd_cnt, 2);
      // R4: a few toggles, bit 5 never rises
      run_case(3, 1000, 2, "R4 settle after toggles");
      // R5: bit 5 rises while toggling, fresh pair settles
      run_case(4, 3, 1, "R5 recheck success");
      chk("R5 reads", rd_cnt, 6);
      // R6: bit 5 rises, still toggling in fresh pair
      run_case(100, 2, 3, "R6 device failure");
      chk("R6 code", last_code, 1);
      // R7: never settles, bit 5 stays low
      run_case(1000, 1000, 1, "R7 loop limit");
      chk("R7 code", last_code, 2);
      chk("R7 reads", rd_cnt, MAXL + 1);

      // R8: start pulses while busy are ignored
      launch(100, 6, 2);
      repeat (3) begin
         @(negedge clk); start_i = 1'b1; addr_i = exp_addr ^ 16'h00FF;
         @(negedge clk); start_i = 1'b0;
      end
      finish_case(100, 6, "R8 start ignored while busy");
      chk("R8 single result", done_cnt + err_cnt, 1);

      // R9: abort, then a fresh start
      launch(1000, 1000, 2);
      while (rd_cnt < 5) @(negedge clk);
      while (bus_rd_o || dev_pend) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 idle after abort", int'(busy_o), 0);
      chk("R9 no result after abort", done_cnt + err_cnt + wr_cnt, 0);
      run_case(2, 1000, 1, "R9 restart from fresh pair");
      r = model(2, 1000, nr);
      chk("R9 restart reads", rd_cnt, nr);

      // random mix
      for (int i = 0; i < 40; i++) begin
         int t, f, lat;
         t   = int'($urandom_range(0, 22));
         f   = ($urandom_range(0, 3) == 0) ? 1000 : int'($urandom_range(0, 24));
         lat = int'($urandom_range(1, 3));
         r = model(t, f, nr);
         run_case(t, f, lat, r == 0 ? "R3 random" : (r == 1 ? "R6 random" : "R7 random"));
      end

      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule